// File: doc/BRIEF.md
# I2C Master Transfer Byte Counter

This block tracks the length of a master-mode I2C transfer. The host programs a byte count while the bus is idle. The bus engine then reports start conditions, stop conditions and finished bytes. The counter takes one off the working count for each byte. When the last byte finishes, it asks the engine for one of two things, chosen by a stop-enable input:

- a stop condition, or
- holding SCL low, so that the host can reprogram and follow with a repeated start.

At that same point it raises a ready flag, and the working count is refilled from the saved value.

A programmed value of zero stands for the full range, which is 2^W bytes (65536 at the default width). A read returns the bytes still outstanding while a transfer segment runs. At any other time it returns the saved value. While the controller is in slave mode, every bus event is ignored.

Top module: `i2c_xfer_counter`

## Requirements
- R1: While no segment is active, a host write loads both the saved value and the working count, and a read returns the written value.
- R2: From a start condition on, a read returns N minus the number of byte-done strobes seen so far (modulo 2^W), where N is the programmed length.
- R3: A programmed value of 0 means 2^W bytes, and a value of 1 means one byte.
- R4: If stop_en is 1 on the last byte-done strobe, stop_req is high for exactly the following cycle and hold_scl_req stays low.
- R5: If stop_en is 0 on the last byte-done strobe, hold_scl_req is high for exactly the following cycle and stop_req stays low.
- R6: rdy_flag goes high in the cycle after the last byte. It stays high until a cycle with host_rdy_clr = 1. A set in the same cycle as a clear wins.
- R7: After the last byte, a read returns the saved value. A following start runs a segment of the same length again.
- R8: After a synchronous reset, reads return 0 and all three outputs are 0.
- R9: While master_mode is 0, start, stop and byte-done strobes change neither the read value nor any output.
- R10: A host write while a segment is active has no effect.
- R11: A stop condition in the middle of a segment ends it. Reads then return the saved value, and no request or ready flag is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 when the controller acts as bus master |
| stop_en | input | 1 | Selects the action at terminal count: 1 requests a stop, 0 holds SCL low |
| host_wr_en | input | 1 | Host write strobe for the count |
| host_wr_data | input | W | Count value to program |
| host_rdy_clr | input | 1 | Host write-1-to-clear strobe for the ready flag |
| host_rd_data | output | W | Remaining count during a segment, saved value otherwise |
| bus_start | input | 1 | Start or repeated-start strobe from the bus engine |
| bus_stop | input | 1 | Stop-condition strobe from the bus engine |
| byte_done | input | 1 | One-cycle strobe per byte sent or received |
| stop_req | output | 1 | One-cycle request for a stop condition |
| hold_scl_req | output | 1 | One-cycle request to hold SCL low |
| rdy_flag | output | 1 | Access-ready flag |

## Verification
A working count that is wrong shows up on host_rd_data in the cycle after the byte-done strobe that caused it. The bench reads the count after every byte. A wrong terminal decision shows up one cycle after the last strobe: the pulse is missing, early or of the wrong kind. A saved value that is not restored shows up on the first read after terminal count or after a stop. A stuck or lost segment-active state shows up at once, because host_rd_data then returns the wrong one of its two sources.

// File: rtl/i2c_cnt_pkg.sv
package i2c_cnt_pkg;

    typedef struct packed {
        logic start;
        logic stop;
        logic byte_done;
    } bus_evt_t;

    typedef enum logic [1:0] {
        TC_NONE = 2'd0,
        TC_STOP = 2'd1,
        TC_HOLD = 2'd2
    } tc_kind_e;

    function automatic tc_kind_e pick_tc(input logic last, input logic stop_en);
        if (!last)
            return TC_NONE;
        return stop_en ? TC_STOP : TC_HOLD;
    endfunction

endpackage

// File: rtl/cnt_evt_gate.sv
module cnt_evt_gate
    import i2c_cnt_pkg::*;
(
    input  logic     master_mode,
    input  bus_evt_t evt_in,
    output bus_evt_t evt_out
);
    always_comb begin
        evt_out = '0;
        if (master_mode)
            evt_out = evt_in;
    end
endmodule

// File: rtl/cnt_core.sv
module cnt_core
    import i2c_cnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_evt_t     evt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         last_byte
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] saved_q;
    logic [W-1:0] work_q;
    logic         active_q;
    logic         wr_ok;
    logic [W-1:0] saved_nx;

    assign wr_ok     = wr_en && !active_q;
    assign saved_nx  = wr_ok ? wr_data : saved_q;
    assign last_byte = evt.byte_done && active_q && !evt.start && !evt.stop
                       && (work_q == ONE);
    assign rd_data   = active_q ? work_q : saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_q  <= '0;
            work_q   <= '0;
            active_q <= 1'b0;
        end else begin
            saved_q <= saved_nx;
            if (evt.start) begin
                active_q <= 1'b1;
                work_q   <= saved_nx;
            end else if (evt.stop || last_byte) begin
                active_q <= 1'b0;
                work_q   <= saved_nx;
            end else if (wr_ok) begin
                work_q <= wr_data;
            end else if (evt.byte_done && active_q) begin
                work_q <= work_q - ONE;
            end
        end
    end
endmodule

// File: rtl/cnt_term.sv
module cnt_term
    import i2c_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic last_byte,
    input  logic stop_en,
    input  logic rdy_clr,
    output logic stop_req,
    output logic hold_req,
    output logic rdy
);
    tc_kind_e kind_d;
    tc_kind_e kind_q;
    logic     rdy_q;

    assign kind_d   = pick_tc(last_byte, stop_en);
    assign stop_req = (kind_q == TC_STOP);
    assign hold_req = (kind_q == TC_HOLD);
    assign rdy      = rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= TC_NONE;
            rdy_q  <= 1'b0;
        end else begin
            kind_q <= kind_d;
            if (last_byte)
                rdy_q <= 1'b1;
            else if (rdy_clr)
                rdy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_xfer_counter.sv
module i2c_xfer_counter
    import i2c_cnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         master_mode,
    input  logic         stop_en,
    input  logic         host_wr_en,
    input  logic [W-1:0] host_wr_data,
    input  logic         host_rdy_clr,
    output logic [W-1:0] host_rd_data,
    input  logic         bus_start,
    input  logic         bus_stop,
    input  logic         byte_done,
    output logic         stop_req,
    output logic         hold_scl_req,
    output logic         rdy_flag
);
    bus_evt_t evt_raw;
    bus_evt_t evt_q;
    logic     last_byte;

    assign evt_raw = '{start: bus_start, stop: bus_stop, byte_done: byte_done};

    cnt_evt_gate u_gate (
        .master_mode (master_mode),
        .evt_in      (evt_raw),
        .evt_out     (evt_q)
    );

    cnt_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_q),
        .wr_en     (host_wr_en),
        .wr_data   (host_wr_data),
        .rd_data   (host_rd_data),
        .last_byte (last_byte)
    );

    cnt_term u_term (
        .clk       (clk),
        .rst       (rst),
        .last_byte (last_byte),
        .stop_en   (stop_en),
        .rdy_clr   (host_rdy_clr),
        .stop_req  (stop_req),
        .hold_req  (hold_scl_req),
        .rdy       (rdy_flag)
    );
endmodule

// File: rtl/i2c_xfer_counter_chk.sv
module i2c_xfer_counter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         master_mode,
    input logic         host_wr_en,
    input logic         host_rdy_clr,
    input logic [W-1:0] host_rd_data,
    input logic         stop_req,
    input logic         hold_scl_req,
    input logic         rdy_flag
);
    // R4
    stop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stop_req);

    // R5
    hold_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hold_scl_req |=> !hold_scl_req);

    // R4
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(stop_req && hold_scl_req));

    // R6
    rdy_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_req || hold_scl_req) |-> rdy_flag);

    // R6
    rdy_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rdy_flag && !host_rdy_clr) |=> rdy_flag);

    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!master_mode && !host_wr_en) |=> ($stable(host_rd_data) && !stop_req && !hold_scl_req));
endmodule

bind i2c_xfer_counter i2c_xfer_counter_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .master_mode  (master_mode),
    .host_wr_en   (host_wr_en),
    .host_rdy_clr (host_rdy_clr),
    .host_rd_data (host_rd_data),
    .stop_req     (stop_req),
    .hold_scl_req (hold_scl_req),
    .rdy_flag     (rdy_flag)
);

// File: tb/test_i2c_xfer_counter.sv
`timescale 1ns/1ps
module test_i2c_xfer_counter;
    localparam int W    = 4;
    localparam int FULL = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         master_mode = 1'b1;
    logic         stop_en = 1'b1;
    logic         host_wr_en = 1'b0;
    logic [W-1:0] host_wr_data = '0;
    logic         host_rdy_clr = 1'b0;
    logic [W-1:0] host_rd_data;
    logic         bus_start = 1'b0;
    logic         bus_stop = 1'b0;
    logic         byte_done = 1'b0;
    logic         stop_req;
    logic         hold_scl_req;
    logic         rdy_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    i2c_xfer_counter #(.W(W)) i_i2c_xfer_counter (
        .clk          (clk),
        .rst          (rst),
        .master_mode  (master_mode),
        .stop_en      (stop_en),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rdy_clr (host_rdy_clr),
        .host_rd_data (host_rd_data),
        .bus_start    (bus_start),
        .bus_stop     (bus_stop),
        .byte_done    (byte_done),
        .stop_req     (stop_req),
        .hold_scl_req (hold_scl_req),
        .rdy_flag     (rdy_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int v);
        host_wr_en = 1'b1; host_wr_data = W'(v);
        @(negedge clk); host_wr_en = 1'b0;
    endtask

    task automatic start_p();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic stop_p();
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic byte_p();
        byte_done = 1'b1; @(negedge clk); byte_done = 1'b0;
    endtask

    task automatic clr_rdy();
        host_rdy_clr = 1'b1; @(negedge clk); host_rdy_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8
        check("R8 read", host_rd_data, 0);
        check("R8 stop", stop_req, 0);
        check("R8 hold", hold_scl_req, 0);
        check("R8 rdy", rdy_flag, 0);

        // Sweep over every programmed value and both terminal actions.
        for (int se = 0; se < 2; se++) begin
            for (int v = 0; v < FULL; v++) begin
                int n;
                n = (v == 0) ? FULL : v;
                stop_en = se[0];
                clr_rdy();
                wr(v);
                check("R1 read after write", host_rd_data, v);
                start_p();
                check("R2 read at start", host_rd_data, n % FULL);
                for (int k = 1; k < n; k++) begin
                    byte_p();
                    check("R2 remaining", host_rd_data, (n - k) % FULL);
                    if (stop_req || hold_scl_req || rdy_flag)
                        check("R3 early terminal", 1, 0);
                end
                byte_p();
                if (v < 2)
                    check("R3 terminal at length", stop_req | hold_scl_req, 1);
                if (se == 1)
                    check("R4 stop_req", {stop_req, hold_scl_req}, 2);
                else
                    check("R5 hold_scl_req", {stop_req, hold_scl_req}, 1);
                check("R6 rdy set", rdy_flag, 1);
                check("R7 reload read", host_rd_data, v);
                @(negedge clk);
                check("R4 R5 pulse width", {stop_req, hold_scl_req}, 0);
                check("R6 rdy held", rdy_flag, 1);
            end
        end

        // R7: a repeated start runs the same length again
        stop_en = 1'b0;
        clr_rdy();
        check("R6 rdy cleared", rdy_flag, 0);
        wr(3);
        start_p(); byte_p(); byte_p(); byte_p();
        check("R7 first segment", hold_scl_req, 1);
        clr_rdy();
        start_p();
        check("R7 restart read", host_rd_data, 3);
        byte_p(); byte_p();
        check("R7 not yet", hold_scl_req, 0);
        byte_p();
        check("R7 second segment", hold_scl_req, 1);

        // R6: set wins over clear in the same cycle
        clr_rdy();
        stop_en = 1'b1;
        wr(1);
        start_p();
        host_rdy_clr = 1'b1;
        byte_p();
        host_rdy_clr = 1'b0;
        check("R6 set beats clear", rdy_flag, 1);
        clr_rdy();

        // R10: write during a segment is ignored
        wr(5);
        start_p(); byte_p();
        wr(9);
        check("R10 remaining", host_rd_data, 4);
        byte_p(); byte_p(); byte_p();
        check("R10 no early stop", stop_req, 0);
        byte_p();
        check("R10 stop at old length", stop_req, 1);
        check("R10 saved kept", host_rd_data, 5);

        // R11: stop mid-segment
        clr_rdy();
        start_p(); byte_p(); byte_p();
        stop_p();
        check("R11 read saved", host_rd_data, 5);
        byte_p();
        check("R11 no request", stop_req | hold_scl_req, 0);
        check("R11 no rdy", rdy_flag, 0);
        check("R11 read idle", host_rd_data, 5);

        // R9: slave mode ignores bus events
        wr(2);
        master_mode = 1'b0;
        start_p();
        check("R9 start ignored", host_rd_data, 2);
        byte_p(); byte_p(); byte_p();
        check("R9 bytes ignored", host_rd_data, 2);
        check("R9 no request", stop_req | hold_scl_req, 0);
        check("R9 no rdy", rdy_flag, 0);
        master_mode = 1'b1;
        start_p(); byte_p();
        check("R9 master resumes", host_rd_data, 1);
        master_mode = 1'b0;
        byte_p();
        check("R9 byte in slave", host_rd_data, 1);
        check("R9 no terminal", rdy_flag, 0);
        master_mode = 1'b1;
        stop_p();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule